// File: doc/BRIEF.md
# Flash Command Timing Controller

This block runs byte program, burst program and page erase commands on an on-chip flash array of 8192 bytes. The array is split into 16 pages of 512 bytes. Every pulse is timed in periods of a slow timing clock. The timing clock is derived from the bus clock: one period lasts (divider + 1) bus cycles. The divider is accepted only when the resulting frequency lies between 150 kHz and 200 kHz. After reset it can be set once only. No command runs until it has been set.

Software loads the command, target address and data byte through a small register write port, then pulses `launch`. While a command runs, `busy` is high. When the last timing period ends, `busy` drops and `done` pulses for one cycle. Illegal accesses raise the sticky `acc_err` flag, and software clears it by writing 1 to the status select.

During a burst, the next data byte may be pushed while the current byte is still being programmed. That byte goes to the next address and takes the short continuation time instead of the full byte time. The register port is a plain write strobe with no back-pressure. A push that the controller cannot hold is refused and flagged, and is never stalled.

Top module: `flash_cmd_timer`

## Requirements
- R1: After reset, `busy`, `done`, `acc_err` and `div_set` are all 0.
- R2: A `launch` while `div_set` is 0 sets `acc_err`, `busy` stays 0, and the array is unchanged.
- R3: A divider write (reg_sel 0, value in reg_wdata[7:0]) is accepted only when BUS_HZ/(value+1) lies in [150 kHz, 200 kHz]. An accepted write sets `div_set`. An out-of-range value sets `acc_err` and leaves `div_set` at 0.
- R4: After one accepted divider write, later divider writes are ignored, and command timing keeps using the first value.
- R5: A divider write while `acc_err` is 1 is ignored and does not use up the single allowed write.
- R6: A byte program (command code 1) keeps `busy` high for exactly PROG_TICKS×(divider+1) bus cycles, default 9 periods. `done` is 1 for exactly the one cycle after `busy` falls.
- R7: A burst (command code 2) programs its first byte in PROG_TICKS periods. Each data byte written (reg_sel 3) while the burst is busy and no byte is waiting is stored to the next address (previous + 1) and takes BURST_TICKS periods, default 4. `busy` stays high across the whole chain.
- R8: Programming stores old AND new, so it can only clear bits.
- R9: A page erase (command code 3) sets all bytes of the page given by address bits [12:9] to 0xFF and leaves other pages unchanged. `busy` stays high for ERASE_TICKS×(divider+1) cycles.
- R10: While `busy` is 1, any of the following sets `acc_err`: a write to the command select (1), a write to the address select (2), a data write that is not a queued burst byte, or a `launch`. The running command still completes with its original timing, address and data.
- R11: Writing reg_sel 4 with reg_wdata[0]=1 clears `acc_err`, and writing it with bit 0 = 0 leaves the flag as it is. While `acc_err` is 1, a `launch` does not start a command.
- R12: A `launch` with command code 0 sets `acc_err` and does not start a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Selects the register: 0 divider, 1 command, 2 address, 3 data, 4 status clear |
| reg_wdata | input | REG_W | Write data |
| launch | input | 1 | Starts the loaded command |
| rd_addr | input | 13 | Byte address for array read-back |
| rd_data | output | 8 | Byte stored at rd_addr |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle pulse when a command finishes |
| acc_err | output | 1 | Sticky access-error flag |
| div_set | output | 1 | The timing divider has been accepted |

## Verification
The bench sweeps every legal divider value of a 2 MHz bus clock (9 through 12). For each value it measures the busy length of erase, single program and a three-byte burst in bus cycles. Exact counts at several divider values tell apart an off-by-one in the prescaler from one in the period count, and tell a short continuation from a full-length one. Byte read-back with overlapping data patterns (0xA5 then 0x3C) shows whether the old value is ANDed or overwritten. An erase next to a page that has already been programmed shows whether the erase stays within its page. The bench also tries rejected divider writes below and above the window, and writes while the error flag is set. It then observes the timing afterwards, which shows whether the lock took the first accepted value.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [2:0] {
    SEL_DIV  = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_DATA = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_BURST = 2'd2,
    CMD_ERASE = 2'd3
  } cmd_e;

endpackage

// File: rtl/fcmd_divider.sv
module fcmd_divider #(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 99,
  parameter int DIV_MAX = 132
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_val,
  input  logic             err_flag,
  input  logic             restart,
  input  logic             run,
  output logic             div_set,
  output logic             tick,
  output logic             reject
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_MIN[DIV_W-1:0];
  localparam logic [DIV_W-1:0] MAX_V = DIV_MAX[DIV_W-1:0];

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] presc_q;
  logic             open_w;
  logic             in_range;

  assign open_w   = wr_en && !div_set && !err_flag;
  assign in_range = (wr_val >= MIN_V) && (wr_val <= MAX_V);
  assign reject   = open_w && !in_range;
  assign tick     = run && (presc_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      div_set <= 1'b0;
    end else if (open_w && in_range) begin
      div_q   <= wr_val;
      div_set <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              presc_q <= '0;
    else if (restart)        presc_q <= '0;
    else if (run) begin
      if (presc_q == div_q)  presc_q <= '0;
      else                   presc_q <= presc_q + 1'b1;
    end
  end

  // R4: once accepted, the divider never moves
  a_r4_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    div_set |=> (div_set && $stable(div_q)));
  // R5: a write while the error flag is up never locks the divider
  a_r5_err_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && err_flag && !div_set) |=> !div_set);
  // R3: a locked divider always sits inside the legal window
  a_r3_locked_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    div_set |-> ((div_q >= MIN_V) && (div_q <= MAX_V)));
endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 512,
  localparam int BYTES     = PAGES * PAGE_BYTES,
  localparam int ADDR_W    = $clog2(BYTES),
  localparam int PG_W      = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_en,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [7:0]        pgm_data,
  input  logic              erase_start,
  input  logic [PG_W-1:0]   erase_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              wipe_busy
);
  localparam int WORDS = BYTES / 4;
  localparam int WPP   = PAGE_BYTES / 4;
  localparam int WPP_W = $clog2(WPP);
  localparam logic [WPP_W-1:0] WPP_LAST = WPP_W'(WPP - 1);

  logic [31:0]      mem [WORDS];
  logic [PG_W-1:0]  page_q;
  logic [WPP_W-1:0] widx_q;
  logic [31:0]      rd_word;

  // Erase clears one word per bus cycle, well inside the erase period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wipe_busy <= 1'b0;
      page_q    <= '0;
      widx_q    <= '0;
    end else if (erase_start) begin
      wipe_busy <= 1'b1;
      page_q    <= erase_page;
      widx_q    <= '0;
    end else if (wipe_busy) begin
      widx_q <= widx_q + 1'b1;
      if (widx_q == WPP_LAST) wipe_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe_busy)
      mem[{page_q, widx_q}] <= '1;
    else if (pgm_en)
      mem[pgm_addr[ADDR_W-1:2]][{pgm_addr[1:0], 3'b000} +: 8] <=
        mem[pgm_addr[ADDR_W-1:2]][{pgm_addr[1:0], 3'b000} +: 8] & pgm_data;
  end

  assign rd_word = mem[rd_addr[ADDR_W-1:2]];
  assign rd_data = rd_word[{rd_addr[1:0], 3'b000} +: 8];

  // R9: a page wipe and a byte program never overlap
  a_r9_no_pgm_in_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_busy |-> !pgm_en);
  // R9: an erase start always begins a wipe
  a_r9_wipe_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> wipe_busy);
endmodule

// File: rtl/fcmd_sequencer.sv
module fcmd_sequencer
  import fcmd_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PG_W        = 4,
  parameter int REG_W       = 16,
  parameter int PROG_TICKS  = 9,
  parameter int BURST_TICKS = 4,
  parameter int ERASE_TICKS = 4000,
  localparam int TMAX       = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS,
  localparam int TCNT_W     = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              launch,
  input  logic              div_set,
  input  logic              div_reject,
  input  logic              tick,
  input  logic              wipe_busy,
  output logic              restart,
  output logic              busy,
  output logic              done,
  output logic              acc_err,
  output logic              pgm_en,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              erase_start,
  output logic [PG_W-1:0]   erase_page
);
  localparam logic [TCNT_W-1:0] PROG_LAST  = TCNT_W'(PROG_TICKS - 1);
  localparam logic [TCNT_W-1:0] BURST_LAST = TCNT_W'(BURST_TICKS - 1);
  localparam logic [TCNT_W-1:0] ERASE_LAST = TCNT_W'(ERASE_TICKS - 1);

  cmd_e              cmd_q, op_q;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [7:0]        data_q, cur_data, qdata;
  logic              qvalid;
  logic [TCNT_W-1:0] tcnt;

  logic wr_cmd, wr_addr, wr_data, wr_stat;
  logic launch_bad, start, q_push, bad_write, finish, chain, set_err, clr_err;
  logic unused_hi;

  assign unused_hi = ^reg_wdata[REG_W-1:ADDR_W];

  assign wr_cmd  = reg_we && (reg_sel == SEL_CMD);
  assign wr_addr = reg_we && (reg_sel == SEL_ADDR);
  assign wr_data = reg_we && (reg_sel == SEL_DATA);
  assign wr_stat = reg_we && (reg_sel == SEL_STAT);

  assign launch_bad = launch && (busy || !div_set || acc_err || cmd_q == CMD_NONE);
  assign start      = launch && !launch_bad;
  assign q_push     = wr_data && busy && (op_q == CMD_BURST) && !qvalid;
  assign bad_write  = busy && (wr_cmd || wr_addr || (wr_data && !q_push));
  assign finish     = busy && tick && (tcnt == '0);
  assign chain      = finish && (op_q == CMD_BURST) && (qvalid || q_push);
  assign set_err    = launch_bad || bad_write || div_reject;
  assign clr_err    = wr_stat && reg_wdata[0];

  assign restart     = start || chain;
  assign pgm_en      = finish && (op_q != CMD_ERASE);
  assign pgm_addr    = cur_addr;
  assign pgm_data    = cur_data;
  assign erase_start = start && (cmd_q == CMD_ERASE);
  assign erase_page  = addr_q[ADDR_W-1:ADDR_W-PG_W];

  function automatic logic [TCNT_W-1:0] first_last(input cmd_e c);
    return (c == CMD_ERASE) ? ERASE_LAST : PROG_LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_err  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cmd_q    <= CMD_NONE;
      op_q     <= CMD_NONE;
      addr_q   <= '0;
      cur_addr <= '0;
      data_q   <= '0;
      cur_data <= '0;
      qdata    <= '0;
      qvalid   <= 1'b0;
      tcnt     <= '0;
    end else begin
      done <= 1'b0;
      if (set_err)      acc_err <= 1'b1;
      else if (clr_err) acc_err <= 1'b0;

      if (!busy) begin
        if (wr_cmd)  cmd_q  <= cmd_e'(reg_wdata[1:0]);
        if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
        if (wr_data) data_q <= reg_wdata[7:0];
      end

      if (q_push) begin
        qvalid <= 1'b1;
        qdata  <= reg_wdata[7:0];
      end

      if (start) begin
        busy     <= 1'b1;
        op_q     <= cmd_q;
        cur_addr <= addr_q;
        cur_data <= data_q;
        tcnt     <= first_last(cmd_q);
        qvalid   <= 1'b0;
      end else if (busy && tick) begin
        if (tcnt != '0) begin
          tcnt <= tcnt - 1'b1;
        end else if (chain) begin
          cur_addr <= cur_addr + 1'b1;
          cur_data <= qvalid ? qdata : reg_wdata[7:0];
          qvalid   <= 1'b0;
          tcnt     <= BURST_LAST;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: completion pulse lasts one cycle and marks the fall of busy
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2: nothing runs before the divider is locked
  a_r2_idle_without_div: assert property (@(posedge clk) disable iff (!rst_n)
    !div_set |-> !busy);
  // R10: a launch during a running command raises the error flag
  a_r10_launch_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && busy) |=> acc_err);
  // R7: a waiting burst byte keeps the controller busy past the current byte
  a_r7_chain_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en && op_q == CMD_BURST && qvalid) |=> busy);
  // R9: the page wipe is over by the time an erase reports completion
  a_r9_wipe_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wipe_busy);
endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer #(
  parameter int BUS_HZ      = 20_000_000,
  parameter int F_MIN_HZ    = 150_000,
  parameter int F_MAX_HZ    = 200_000,
  parameter int DIV_W       = 8,
  parameter int PAGES       = 16,
  parameter int PAGE_BYTES  = 512,
  parameter int REG_W       = 16,
  parameter int PROG_TICKS  = 9,
  parameter int BURST_TICKS = 4,
  parameter int ERASE_TICKS = 4000,
  localparam int ADDR_W     = $clog2(PAGES * PAGE_BYTES),
  localparam int PG_W       = $clog2(PAGES),
  localparam int DIV_MIN    = (BUS_HZ + F_MAX_HZ - 1) / F_MAX_HZ - 1,
  localparam int DIV_MAX    = BUS_HZ / F_MIN_HZ - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              launch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              acc_err,
  output logic              div_set
);
  import fcmd_pkg::*;

  logic              div_wr, tick, reject, restart, wipe_busy;
  logic              pgm_en, erase_start;
  logic [ADDR_W-1:0] pgm_addr;
  logic [7:0]        pgm_data;
  logic [PG_W-1:0]   erase_page;

  assign div_wr = reg_we && (reg_sel == SEL_DIV);

  fcmd_divider #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .wr_en(div_wr), .wr_val(reg_wdata[DIV_W-1:0]),
    .err_flag(acc_err), .restart(restart), .run(busy),
    .div_set(div_set), .tick(tick), .reject(reject)
  );

  fcmd_sequencer #(
    .ADDR_W(ADDR_W), .PG_W(PG_W), .REG_W(REG_W), .PROG_TICKS(PROG_TICKS),
    .BURST_TICKS(BURST_TICKS), .ERASE_TICKS(ERASE_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .launch(launch), .div_set(div_set),
    .div_reject(reject), .tick(tick), .wipe_busy(wipe_busy),
    .restart(restart), .busy(busy), .done(done), .acc_err(acc_err),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .erase_start(erase_start), .erase_page(erase_page)
  );

  fcmd_array #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .erase_start(erase_start), .erase_page(erase_page),
    .rd_addr(rd_addr), .rd_data(rd_data), .wipe_busy(wipe_busy)
  );
endmodule

// File: tb/flash_cmd_timer_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_timer_tb_top;
  localparam int BUS_HZ = 2_000_000;
  localparam int ERT    = 150;
  localparam int PT     = 9;
  localparam int BT     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        launch = 1'b0;
  logic [12:0] rd_addr = 13'd0;
  logic [7:0]  rd_data;
  logic        busy, done, acc_err, div_set;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_timer #(
    .BUS_HZ(BUS_HZ), .ERASE_TICKS(ERT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .launch(launch), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .acc_err(acc_err),
    .div_set(div_set)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input int v);
    reg_we = 1'b1; reg_sel = s; reg_wdata = 16'(v);
    step();
    reg_we = 1'b0;
  endtask

  task automatic go();
    launch = 1'b1;
    step();
    launch = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (busy && cnt < 100000) begin
      cnt++;
      step();
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 13'(a);
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cnt, v, e, p, base;
    @(negedge clk);
    for (int d = 9; d <= 12; d++) begin
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 acc_err", acc_err, 0);
      check("R1 div_set", div_set, 0);

      p = 2 * (d - 9);
      base = p << 9;

      // R2 launch before divider
      wr(3'd1, 1); wr(3'd2, base + 5); wr(3'd3, 8'h00);
      go();
      check("R2 acc_err", acc_err, 1);
      check("R2 busy", busy, 0);

      // R5 divider write while error is set
      wr(3'd0, d);
      check("R5 div_set", div_set, 0);

      // R11 clear semantics
      wr(3'd4, 0);
      check("R11 keep on 0", acc_err, 1);
      wr(3'd4, 1);
      check("R11 clear on 1", acc_err, 0);

      // R3 out-of-window values
      wr(3'd0, 8);
      check("R3 low err", acc_err, 1);
      check("R3 low div_set", div_set, 0);
      wr(3'd4, 1);
      wr(3'd0, 13);
      check("R3 high err", acc_err, 1);
      check("R3 high div_set", div_set, 0);
      wr(3'd4, 1);
      wr(3'd0, d);
      check("R3 accept", div_set, 1);
      check("R3 no err", acc_err, 0);

      // R4 second write ignored
      e = (d == 9) ? 12 : 9;
      wr(3'd0, e);
      check("R4 div_set", div_set, 1);
      check("R4 no err", acc_err, 0);

      // R12 command code 0
      wr(3'd1, 0);
      go();
      check("R12 acc_err", acc_err, 1);
      check("R12 busy", busy, 0);
      // R11 launch refused while error set
      wr(3'd1, 1);
      go();
      check("R11 refused launch", busy, 0);
      wr(3'd4, 1);

      // R9 erase neighbour page, then program a byte there
      wr(3'd1, 3); wr(3'd2, base + 512);
      go();
      wait_idle(cnt);
      check("R9 erase cycles", cnt, ERT * (d + 1));
      check("R9 done", done, 1);
      wr(3'd1, 1); wr(3'd2, base + 512 + 7); wr(3'd3, 8'h5A);
      go();
      wait_idle(cnt);
      check("R6 R4 program cycles", cnt, PT * (d + 1));
      check("R6 done high", done, 1);
      step();
      check("R6 done one cycle", done, 0);
      rd(base + 512 + 7, v);
      check("R6 value", v, 8'h5A);

      // R9 erase page p, whole page 0xFF, neighbour kept
      wr(3'd1, 3); wr(3'd2, base);
      go();
      wait_idle(cnt);
      check("R9 erase cycles p", cnt, ERT * (d + 1));
      for (int i = 0; i < 512; i++) begin
        rd(base + i, v);
        check("R9 byte erased", v, 8'hFF);
      end
      rd(base + 512 + 7, v);
      check("R9 neighbour kept", v, 8'h5A);

      // R8 AND semantics
      wr(3'd1, 1); wr(3'd2, base + 3); wr(3'd3, 8'hA5);
      go(); wait_idle(cnt);
      rd(base + 3, v);
      check("R8 first", v, 8'hA5);
      wr(3'd3, 8'h3C);
      go(); wait_idle(cnt);
      rd(base + 3, v);
      check("R8 and", v, 8'hA5 & 8'h3C);

      // R7 three-byte burst
      wr(3'd1, 2); wr(3'd2, base + 8'h40); wr(3'd3, 8'h11);
      go();
      cnt = 0;
      while (busy && cnt < 100000) begin
        cnt++;
        if (cnt == 1) begin
          reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 16'h22;
        end else if (cnt == PT * (d + 1) + 1) begin
          reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 16'h33;
        end
        step();
        reg_we = 1'b0;
      end
      check("R7 burst cycles", cnt, (PT + 2 * BT) * (d + 1));
      check("R7 no err", acc_err, 0);
      rd(base + 8'h40, v); check("R7 byte0", v, 8'h11);
      rd(base + 8'h41, v); check("R7 byte1", v, 8'h22);
      rd(base + 8'h42, v); check("R7 byte2", v, 8'h33);
      rd(base + 8'h43, v); check("R7 stop", v, 8'hFF);

      // R10 illegal accesses while busy
      wr(3'd1, 1); wr(3'd2, base + 8'h80); wr(3'd3, 8'h0F);
      go();
      wr(3'd2, base + 8'h81);
      check("R10 addr write err", acc_err, 1);
      wr(3'd4, 1);
      wr(3'd3, 8'h00);
      check("R10 data write err", acc_err, 1);
      wr(3'd4, 1);
      go();
      check("R10 launch err", acc_err, 1);
      wr(3'd4, 1);
      wait_idle(cnt);
      check("R10 timing kept", cnt + 6, PT * (d + 1));
      rd(base + 8'h80, v); check("R10 data kept", v, 8'h0F);
      rd(base + 8'h81, v); check("R10 addr kept", v, 8'hFF);
    end
    summary();
  end
endmodule